// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals of an incremental quadrature encoder into a signed position count. It also gives the sense of the latest movement and a velocity figure. Both phase inputs are synchronized to the system clock. A small decoder compares each new sample pair with the previous one and issues an up step, a down step or an illegal-transition flag. An accumulator applies the steps to the position register.

Resolution is picked at run time. X1 counts one edge per cycle of phase A, and that edge is either the rising or the falling one, set by a select input. X2 counts both edges of phase A. X4 counts every edge on both phases. The sense of each step comes from which phase leads: A ahead of B counts up, and B ahead of A counts down.

A gate timer runs for a programmable number of clock cycles. At the end of each gate it publishes the position change over that gate as the velocity, together with a one-cycle strobe. If the gate length is set to one second of clock cycles, that difference is already in counts per second.

Top module: `quad_pos_counter`

## Requirements
- R1: While reset is low, and on the first cycle after it, position, velocity, vel_valid, dir_down and illegal_err are all zero.
- R2: With res_mode = 2 (X4), every single-phase edge changes position by one. The sequence {A,B} = 00, 10, 11, 01, 00 (A leading) counts up by one per step, and dir_down reads 0.
- R3: In X4 the reverse sequence (B leading) counts down by one per edge and sets dir_down to 1. res_mode = 3 behaves as X4.
- R4: With res_mode = 1 (X2), both edges of A are counted with the quadrature sense, and edges of B leave position unchanged.
- R5: With res_mode = 0 (X1), only A edges of one polarity are counted: rising when x1_falling = 0, falling when x1_falling = 1. All other edges leave position unchanged.
- R6: A sample in which A and B both changed leaves position unchanged and sets illegal_err. illegal_err stays 1 until reset, even after later valid edges.
- R7: dir_down holds the sense of the most recent counted step (0 up, 1 down). Ignored edges and illegal transitions do not change it.
- R8: Every gate_cycles clock cycles, vel_valid pulses for one cycle. With that pulse, velocity becomes the position at that edge minus the position at the previous pulse (or at reset).
- R9: A phase edge driven between clock edges appears on position at the third rising clock edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| res_mode | input | 2 | 0 X1, 1 X2, 2 or 3 X4 |
| x1_falling | input | 1 | X1 edge select: 0 rising, 1 falling |
| gate_cycles | input | 32 | Velocity gate length in clock cycles (0 treated as 1) |
| position | output | 32 | Signed position count |
| dir_down | output | 1 | Sense of last counted step, 1 = down |
| velocity | output | 32 | Signed position change over last gate |
| vel_valid | output | 1 | One-cycle strobe when velocity updates |
| illegal_err | output | 1 | Sticky flag for a double-phase transition |

## Verification
Position, dir_down and illegal_err follow an input edge after three clock edges: two synchronizer stages, then the accumulator register. The bench drives phases on the falling clock edge and reads results four falling edges later, and one directed test probes the edges just before and just at the third rising edge. Velocity is due on the vel_valid strobe. The bench therefore finds each strobe and moves the encoder only inside a gate, so the motion settles well before the next strobe. It then compares velocity on the falling edge where the strobe is seen, and checks that the strobe has dropped one cycle later.

// File: rtl/qpc_pkg.sv
// Package: shared encodings for the quadrature position counter.
// Assumes: res_mode value 3 is treated as X4 by all users.
package qpc_pkg;
    typedef enum logic [1:0] {
        RES_X1 = 2'd0,
        RES_X2 = 2'd1,
        RES_X4 = 2'd2,
        RES_X4B = 2'd3
    } res_mode_e;

    localparam int DEF_POS_W  = 32;
    localparam int DEF_GATE_W = 32;
endpackage

// File: rtl/qpc_sync.sv
// qpc_sync: multi-stage synchronizer for a bundle of asynchronous bits.
// Assumes: each bit toggles slowly enough relative to clk that bits need
// not be coherent with one another; reset clears every stage to 0.
module qpc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the raw input through STAGES flops.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d_async[g]};
        end

        assign d_sync[g] = chain[LAST];
    end
endmodule

// File: rtl/qpc_decoder.sv
// qpc_decoder: compares the synchronized phase pair with the previous
// sample and emits up/down step pulses according to the resolution mode.
// Assumes: inputs already synchronized; phases are low when reset releases.
module qpc_decoder
    import qpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       a_s,
    input  logic       b_s,
    input  logic [1:0] mode,
    input  logic       x1_fall,
    output logic       step_up,
    output logic       step_dn,
    output logic       illegal
);
    logic prev_a, prev_b;
    logic a_chg, b_chg;
    logic a_fwd, b_fwd;
    logic a_pol_ok;

    // Remember the last sampled phase pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_a <= 1'b0;
            prev_b <= 1'b0;
        end else begin
            prev_a <= a_s;
            prev_b <= b_s;
        end
    end

    // Classify the transition and pick the counting sense.
    always_comb begin
        a_chg    = a_s ^ prev_a;
        b_chg    = b_s ^ prev_b;
        illegal  = a_chg & b_chg;
        a_fwd    = (a_s != b_s);
        b_fwd    = (b_s == a_s);
        a_pol_ok = (a_s == ~x1_fall);
        step_up  = 1'b0;
        step_dn  = 1'b0;
        if (!illegal) begin
            case (res_mode_e'(mode))
                RES_X1: begin
                    if (a_chg && a_pol_ok) begin
                        step_up = a_fwd;
                        step_dn = ~a_fwd;
                    end
                end
                RES_X2: begin
                    if (a_chg) begin
                        step_up = a_fwd;
                        step_dn = ~a_fwd;
                    end
                end
                default: begin
                    if (a_chg) begin
                        step_up = a_fwd;
                        step_dn = ~a_fwd;
                    end else if (b_chg) begin
                        step_up = b_fwd;
                        step_dn = ~b_fwd;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/qpc_accum.sv
// qpc_accum: applies decoder steps to the signed position register, keeps
// the sense of the last step and a sticky illegal-transition flag.
// Assumes: step_up and step_dn are never both high.
module qpc_accum #(
    parameter int POS_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_up,
    input  logic                    step_dn,
    input  logic                    illegal,
    output logic signed [POS_W-1:0] position,
    output logic                    dir_down,
    output logic                    err
);
    // Update position by one step.
    always_ff @(posedge clk) begin
        if (!rst_n)       position <= '0;
        else if (step_up) position <= position + 1'b1;
        else if (step_dn) position <= position - 1'b1;
    end

    // Track the sense of the latest counted step.
    always_ff @(posedge clk) begin
        if (!rst_n)                  dir_down <= 1'b0;
        else if (step_up || step_dn) dir_down <= step_dn;
    end

    // Latch any illegal transition until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       err <= 1'b0;
        else if (illegal) err <= 1'b1;
    end

    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((position == $past(position)) ||
                  (position == $past(position) + 1) ||
                  (position == $past(position) - 1)));

    assert_illegal_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> $stable(position));

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    assert_dir_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up || step_dn) |=> $stable(dir_down));
endmodule

// File: rtl/qpc_velocity.sv
// qpc_velocity: gate timer that publishes the position change over each
// gate interval with a one-cycle strobe.
// Assumes: gate_cycles is held steady during operation; 0 acts as 1.
module qpc_velocity #(
    parameter int POS_W  = 32,
    parameter int GATE_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [GATE_W-1:0]       gate_cycles,
    input  logic signed [POS_W-1:0] position,
    output logic signed [POS_W-1:0] velocity,
    output logic                    vel_valid
);
    logic [GATE_W-1:0]       gate_cnt;
    logic [GATE_W-1:0]       gate_lim;
    logic                    gate_end;
    logic signed [POS_W-1:0] last_pos;

    // Derive the terminal count of the gate timer.
    always_comb begin
        gate_lim = (gate_cycles == '0) ? '0 : gate_cycles - 1'b1;
        gate_end = (gate_cnt >= gate_lim);
    end

    // Advance the gate timer and wrap at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)        gate_cnt <= '0;
        else if (gate_end) gate_cnt <= '0;
        else               gate_cnt <= gate_cnt + 1'b1;
    end

    // Publish the position difference at each gate end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_pos  <= '0;
            velocity  <= '0;
            vel_valid <= 1'b0;
        end else begin
            vel_valid <= gate_end;
            if (gate_end) begin
                velocity <= position - last_pos;
                last_pos <= position;
            end
        end
    end

    assert_strobe_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vel_valid && gate_cycles > 1) |=> !vel_valid);

    assert_vel_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!vel_valid && !$past(gate_end)) |-> $stable(velocity));
endmodule

// File: rtl/quad_pos_counter.sv
// quad_pos_counter: quadrature encoder position, direction and velocity.
// Assumes: phases are asynchronous to clk and low at reset release;
// configuration inputs change only while the encoder is idle.
module quad_pos_counter #(
    parameter int POS_W       = qpc_pkg::DEF_POS_W,
    parameter int GATE_W      = qpc_pkg::DEF_GATE_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    phase_a,
    input  logic                    phase_b,
    input  logic [1:0]              res_mode,
    input  logic                    x1_falling,
    input  logic [GATE_W-1:0]       gate_cycles,
    output logic signed [POS_W-1:0] position,
    output logic                    dir_down,
    output logic signed [POS_W-1:0] velocity,
    output logic                    vel_valid,
    output logic                    illegal_err
);
    logic [1:0] ph_sync;
    logic       step_up, step_dn, illegal;

    qpc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({phase_b, phase_a}),
        .d_sync  (ph_sync)
    );

    qpc_decoder u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_s     (ph_sync[0]),
        .b_s     (ph_sync[1]),
        .mode    (res_mode),
        .x1_fall (x1_falling),
        .step_up (step_up),
        .step_dn (step_dn),
        .illegal (illegal)
    );

    qpc_accum #(.POS_W(POS_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_up  (step_up),
        .step_dn  (step_dn),
        .illegal  (illegal),
        .position (position),
        .dir_down (dir_down),
        .err      (illegal_err)
    );

    qpc_velocity #(.POS_W(POS_W), .GATE_W(GATE_W)) u_vel (
        .clk         (clk),
        .rst_n       (rst_n),
        .gate_cycles (gate_cycles),
        .position    (position),
        .velocity    (velocity),
        .vel_valid   (vel_valid)
    );
endmodule

// File: tb/quad_pos_counter_bench.sv
`timescale 1ns/1ps
module quad_pos_counter_bench;
    logic               clk = 1'b0;
    logic               rst_n;
    logic               phase_a, phase_b, x1_falling;
    logic [1:0]         res_mode;
    logic [31:0]        gate_cycles;
    logic signed [31:0] position, velocity;
    logic               dir_down, vel_valid, illegal_err;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    quad_pos_counter u_quad_pos_counter (
        .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
        .res_mode(res_mode), .x1_falling(x1_falling), .gate_cycles(gate_cycles),
        .position(position), .dir_down(dir_down), .velocity(velocity),
        .vel_valid(vel_valid), .illegal_err(illegal_err)
    );

    // Vector: [15:14] mode, [13] x1_falling, [12] A, [11] B, [10] dir, [7:0] pos
    localparam logic [15:0] VEC [0:22] = '{
        {2'd2,1'b0,1'b1,1'b0,1'b0,2'b00,8'd1},
        {2'd2,1'b0,1'b1,1'b1,1'b0,2'b00,8'd2},
        {2'd2,1'b0,1'b0,1'b1,1'b0,2'b00,8'd3},
        {2'd2,1'b0,1'b0,1'b0,1'b0,2'b00,8'd4},
        {2'd2,1'b0,1'b0,1'b1,1'b1,2'b00,8'd3},
        {2'd2,1'b0,1'b1,1'b1,1'b1,2'b00,8'd2},
        {2'd1,1'b0,1'b1,1'b0,1'b1,2'b00,8'd2},
        {2'd1,1'b0,1'b0,1'b0,1'b1,2'b00,8'd1},
        {2'd1,1'b0,1'b1,1'b0,1'b0,2'b00,8'd2},
        {2'd1,1'b0,1'b1,1'b1,1'b0,2'b00,8'd2},
        {2'd1,1'b0,1'b0,1'b1,1'b0,2'b00,8'd3},
        {2'd0,1'b0,1'b0,1'b0,1'b0,2'b00,8'd3},
        {2'd0,1'b0,1'b1,1'b0,1'b0,2'b00,8'd4},
        {2'd0,1'b0,1'b1,1'b1,1'b0,2'b00,8'd4},
        {2'd0,1'b0,1'b0,1'b1,1'b0,2'b00,8'd4},
        {2'd0,1'b0,1'b0,1'b0,1'b0,2'b00,8'd4},
        {2'd0,1'b0,1'b0,1'b1,1'b0,2'b00,8'd4},
        {2'd0,1'b0,1'b1,1'b1,1'b1,2'b00,8'd3},
        {2'd0,1'b1,1'b0,1'b1,1'b0,2'b00,8'd4},
        {2'd0,1'b1,1'b1,1'b1,1'b0,2'b00,8'd4},
        {2'd0,1'b1,1'b1,1'b0,1'b0,2'b00,8'd4},
        {2'd0,1'b1,1'b0,1'b0,1'b1,2'b00,8'd3},
        {2'd3,1'b0,1'b0,1'b1,1'b1,2'b00,8'd2}
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [31:0] gate);
        rst_n = 1'b0; phase_a = 1'b0; phase_b = 1'b0;
        res_mode = 2'd2; x1_falling = 1'b0; gate_cycles = gate;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step_to(input logic a, input logic b);
        @(negedge clk);
        phase_a = a; phase_b = b;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_strobe();
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (vel_valid) break;
        end
    endtask

    initial begin
        do_reset(32'd1000);
        // R1: reset state while reset is asserted
        rst_n = 1'b0;
        @(negedge clk);
        check(position == 0 && velocity == 0 && !vel_valid && !dir_down && !illegal_err,
              "R1 reset state", position, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(position == 0 && !illegal_err && !dir_down, "R1 first cycle after reset", position, 0);

        // Table walk: R2/R3 (X4), R4 (X2), R5 (X1), R7 (direction)
        for (int i = 0; i < 23; i++) begin
            logic [15:0] v;
            string tag;
            v = VEC[i];
            @(negedge clk);
            res_mode = v[15:14]; x1_falling = v[13];
            phase_a = v[12]; phase_b = v[11];
            repeat (4) @(negedge clk);
            case (v[15:14])
                2'd0: tag = "R5 X1 count";
                2'd1: tag = "R4 X2 count";
                2'd3: tag = "R3 mode3 as X4";
                default: tag = (v[10]) ? "R3 X4 reverse" : "R2 X4 forward";
            endcase
            check(position == 32'(v[7:0]), tag, position, v[7:0]);
            check(dir_down == v[10], "R7 direction", dir_down, v[10]);
        end

        // R6: illegal double change 01 -> 10
        res_mode = 2'd2;
        step_to(1'b1, 1'b0);
        check(position == 2, "R6 illegal holds position", position, 2);
        check(illegal_err == 1'b1, "R6 illegal sets flag", illegal_err, 1);
        check(dir_down == 1'b1, "R7 illegal keeps direction", dir_down, 1);
        step_to(1'b1, 1'b1);
        check(position == 3, "R2 count after illegal", position, 3);
        check(illegal_err == 1'b1, "R6 flag sticky", illegal_err, 1);
        check(dir_down == 1'b0, "R7 direction follows up step", dir_down, 0);

        // R1: reset clears everything after activity
        do_reset(32'd64);
        @(negedge clk);
        check(position == 0 && !illegal_err && !dir_down, "R1 reset clears state", position, 0);

        // R8: velocity over gates
        wait_strobe();
        check(vel_valid == 1'b1, "R8 strobe seen", vel_valid, 1);
        check(velocity == 0, "R8 idle first gate", velocity, 0);
        @(negedge clk);
        check(vel_valid == 1'b0, "R8 strobe one cycle", vel_valid, 0);
        phase_a = 1'b1; repeat (4) @(negedge clk);
        phase_b = 1'b1; repeat (4) @(negedge clk);
        phase_a = 1'b0; repeat (4) @(negedge clk);
        phase_b = 1'b0; repeat (4) @(negedge clk);
        phase_a = 1'b1; repeat (4) @(negedge clk);
        wait_strobe();
        check(velocity == 5, "R8 velocity over moving gate", velocity, 5);
        wait_strobe();
        check(velocity == 0, "R8 velocity over still gate", velocity, 0);

        // R9: latency of an edge to position (position is 5 here)
        @(negedge clk);
        phase_b = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check(position == 5, "R9 no change before third edge", position, 5);
        @(posedge clk);
        @(negedge clk);
        check(position == 6, "R9 change at third edge", position, 6);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule